// File: doc/BRIEF.md
# Mixed-Aspect Two-Port RAM

This block is a synchronous simple dual-port memory. One port only writes and the other only reads. The two ports may have different word widths and depths, as long as both describe the same number of stored bits. Where the widths differ, the narrower port addresses sub-words of the wider word. The narrow address with the lowest value covers the least significant bits of the wide word.

A read is always registered once. While the read enable is inactive, the read stage loads zero, so the output drops to zero instead of holding the last word. An optional output register can follow the read stage, chosen by a static parameter. That register has its own clock enable, a synchronous clear and an asynchronous clear. The asynchronous clear wins over everything else, and the synchronous clear acts only when the register enable is active.

The block can run from one shared clock, with a parameter that selects the active edge, or from separate write and read clocks. Each enable and each reset input has its own polarity parameter: active-low, active-high, or tied off. A tied-off enable is always active, and a tied-off reset is never asserted. A read and a write to the same address in the same cycle give an undefined result, and the block does not detect this case.

Top module: `mw_tpram`

## Requirements
- R1: A word written through the write port can be read back through the read port. If the write word holds N read words, write word `a` covers read addresses a*N to a*N+N-1, with the lowest of these in bits [RD_W-1:0]. If the read word holds N write words, read word `b` is built from write addresses b*N to b*N+N-1, with the lowest of these in the least significant bits.
- R2: When the write enable is inactive at a write-clock edge, the memory contents do not change.
- R3: When the read enable is inactive at a read-clock edge, the read stage loads zero.
- R4: With the output register present, an active asynchronous reset forces the read data to zero at once, with no clock edge needed.
- R5: The asynchronous reset leaves the stored memory contents untouched.
- R6: With the output register present and the register enable inactive, the read data holds its value across read-clock edges.
- R7: With the output register present, the register enable active and the synchronous reset active, a read-clock edge clears the read data. When the register enable is inactive, the synchronous reset has no effect.
- R8: With the output register present, the register enable active and both resets inactive, the read data shows the word at the read address two read-clock edges after that address is applied.
- R9: With the output register bypassed, the read data shows the addressed word one read-clock edge after the address is applied. The register enable and both reset inputs have no effect on the output.
- R10: A polarity parameter of 0 makes its input active-low, and a value of 1 makes it active-high. A polarity of 2 ties an enable to active, or a reset to inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, used when SINGLE_CLK=1 (edge set by FALL_EDGE) |
| wr_clk | input | 1 | Write clock, used when SINGLE_CLK=0 |
| rd_clk | input | 1 | Read clock, used when SINGLE_CLK=0 |
| wr_en | input | 1 | Write enable, polarity WE_POL |
| wr_addr | input | $clog2(WR_D) | Write address |
| wr_data | input | WR_W | Write data |
| rd_en | input | 1 | Read enable, polarity RE_POL |
| rd_addr | input | $clog2(RD_D) | Read address |
| rd_data | output | RD_W | Read data |
| oreg_en | input | 1 | Output register enable, polarity OE_POL |
| oreg_srst | input | 1 | Output register synchronous clear, polarity SRST_POL |
| oreg_arst | input | 1 | Output register asynchronous clear, polarity ARST_POL |

## Verification
The bench writes with one width and reads back with the other, using two configurations: write wider than read, and read wider than write. A design that swapped sub-word order or mis-scaled the address would return halves in the wrong place. In the output register, the bench covers several precedence cases: an inactive enable with an active synchronous clear, which must hold the output; an asynchronous clear between clock edges, which must clear it at once; and a read after the asynchronous clear, which shows the memory was not wiped. A bypassed instance toggles all three register controls and still expects one-edge latency and an unchanged output, which catches a controls path that leaks through.

// File: rtl/mw_tpram_pkg.sv
`timescale 1ns/1ps
package mw_tpram_pkg;
   localparam int POL_LOW  = 0;
   localparam int POL_HIGH = 1;
   localparam int POL_TIED = 2;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int imin(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/mw_pol_decode.sv
`timescale 1ns/1ps
module mw_pol_decode
   import mw_tpram_pkg::*;
#(
   parameter int POL      = POL_HIGH,
   parameter bit TIED_VAL = 1'b1
) (
   input  logic pin,
   output logic act
);
   generate
      if (POL < POL_LOW || POL > POL_TIED) begin : g_bad_pol
         $error("polarity selector out of range");
      end
      if (POL == POL_TIED) begin : g_tied
         logic unused_pin;
         assign unused_pin = pin;
         assign act = TIED_VAL;
      end else if (POL == POL_LOW) begin : g_low
         assign act = ~pin;
      end else begin : g_high
         assign act = pin;
      end
   endgenerate
endmodule

// File: rtl/mw_store.sv
`timescale 1ns/1ps
module mw_store
   import mw_tpram_pkg::*;
#(
   parameter  int WW = 16,
   parameter  int WD = 16,
   parameter  int RW = 8,
   parameter  int RD = 32,
   localparam int WA = $clog2(WD),
   localparam int RA = $clog2(RD)
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [WA-1:0] waddr,
   input  logic [WW-1:0] wdata,
   input  logic          rclk,
   input  logic          re,
   input  logic [RA-1:0] raddr,
   output logic [RW-1:0] rword
);
   localparam int UW    = imin(WW, RW);
   localparam int WPU   = WW / UW;
   localparam int RPU   = RW / UW;
   localparam int UNITS = (WW * WD) / UW;
   localparam int UA    = $clog2(UNITS);
   localparam int WSH   = $clog2(WPU);
   localparam int RSH   = $clog2(RPU);

   logic [UW-1:0] mem [UNITS];
   logic [UA-1:0] wbase;
   logic [UA-1:0] rbase;

   assign wbase = UA'(waddr) << WSH;
   assign rbase = UA'(raddr) << RSH;

   always_ff @(posedge wclk) begin
      if (we) begin
         for (int k = 0; k < WPU; k++) begin
            mem[wbase | UA'(k)] <= wdata[k*UW +: UW];
         end
      end
   end

   always_ff @(posedge rclk) begin
      for (int k = 0; k < RPU; k++) begin
         rword[k*UW +: UW] <= re ? mem[rbase | UA'(k)] : '0;
      end
   end
endmodule

// File: rtl/mw_outreg.sv
`timescale 1ns/1ps
module mw_outreg #(
   parameter int W    = 8,
   parameter bit PIPE = 1'b1
) (
   input  logic         rclk,
   input  logic         arst,
   input  logic         en,
   input  logic         srst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (PIPE) begin : g_pipe
         always_ff @(posedge rclk or posedge arst) begin
            if (arst)     q <= '0;
            else if (en)  q <= srst ? '0 : d;
         end
      end else begin : g_bypass
         logic unused_ctl;
         assign unused_ctl = arst ^ en ^ srst;
         assign q = d;
      end
   endgenerate
endmodule

// File: rtl/mw_tpram.sv
`timescale 1ns/1ps
module mw_tpram
   import mw_tpram_pkg::*;
#(
   parameter  int WR_W       = 16,
   parameter  int WR_D       = 16,
   parameter  int RD_W       = 8,
   parameter  int RD_D       = 32,
   parameter  bit PIPE       = 1'b1,
   parameter  bit SINGLE_CLK = 1'b1,
   parameter  bit FALL_EDGE  = 1'b0,
   parameter  int WE_POL     = POL_HIGH,
   parameter  int RE_POL     = POL_HIGH,
   parameter  int OE_POL     = POL_HIGH,
   parameter  int SRST_POL   = POL_LOW,
   parameter  int ARST_POL   = POL_LOW,
   localparam int WA         = $clog2(WR_D),
   localparam int RA         = $clog2(RD_D)
) (
   input  logic            clk,
   input  logic            wr_clk,
   input  logic            rd_clk,
   input  logic            wr_en,
   input  logic [WA-1:0]   wr_addr,
   input  logic [WR_W-1:0] wr_data,
   input  logic            rd_en,
   input  logic [RA-1:0]   rd_addr,
   output logic [RD_W-1:0] rd_data,
   input  logic            oreg_en,
   input  logic            oreg_srst,
   input  logic            oreg_arst
);
   localparam int NARROW = imin(WR_W, RD_W);
   localparam int WIDE   = imax(WR_W, RD_W);

   generate
      if (WR_W * WR_D != RD_W * RD_D) begin : g_bad_cap
         $error("write and read capacities differ");
      end
      if (WIDE % NARROW != 0 || !is_pow2(WIDE / NARROW)) begin : g_bad_ratio
         $error("width ratio must be a power of two");
      end
      if (!is_pow2(WR_D) || !is_pow2(RD_D) || WR_D < 2 || RD_D < 2) begin : g_bad_depth
         $error("depths must be powers of two, at least 2");
      end
   endgenerate

   logic wck, rck;
   generate
      if (SINGLE_CLK) begin : g_one_clk
         logic unused_sep;
         assign unused_sep = wr_clk ^ rd_clk;
         assign wck = FALL_EDGE ? ~clk : clk;
         assign rck = wck;
      end else begin : g_two_clk
         logic unused_clk;
         assign unused_clk = clk;
         assign wck = wr_clk;
         assign rck = rd_clk;
      end
   endgenerate

   logic we_act, re_act, oen_act, srst_act, arst_act;

   mw_pol_decode #(.POL(WE_POL),   .TIED_VAL(1'b1)) u_we   (.pin(wr_en),     .act(we_act));
   mw_pol_decode #(.POL(RE_POL),   .TIED_VAL(1'b1)) u_re   (.pin(rd_en),     .act(re_act));
   mw_pol_decode #(.POL(OE_POL),   .TIED_VAL(1'b1)) u_oen  (.pin(oreg_en),   .act(oen_act));
   mw_pol_decode #(.POL(SRST_POL), .TIED_VAL(1'b0)) u_srst (.pin(oreg_srst), .act(srst_act));
   mw_pol_decode #(.POL(ARST_POL), .TIED_VAL(1'b0)) u_arst (.pin(oreg_arst), .act(arst_act));

   logic [RD_W-1:0] rword;

   mw_store #(.WW(WR_W), .WD(WR_D), .RW(RD_W), .RD(RD_D)) u_store (
      .wclk (wck),
      .we   (we_act),
      .waddr(wr_addr),
      .wdata(wr_data),
      .rclk (rck),
      .re   (re_act),
      .raddr(rd_addr),
      .rword(rword)
   );

   mw_outreg #(.W(RD_W), .PIPE(PIPE)) u_oreg (
      .rclk(rck),
      .arst(arst_act),
      .en  (oen_act),
      .srst(srst_act),
      .d   (rword),
      .q   (rd_data)
   );
endmodule

// File: rtl/mw_tpram_chk.sv
`timescale 1ns/1ps
module mw_tpram_chk #(
   parameter bit PIPE = 1'b1,
   parameter int RW   = 8
) (
   input logic          rck,
   input logic          arst_act,
   input logic          en_act,
   input logic          srst_act,
   input logic          re_act,
   input logic [RW-1:0] rword,
   input logic [RW-1:0] rd_data
);
   // R3
   rd_off_zero_chk: assert property (@(posedge rck) disable iff (arst_act)
      !re_act |=> (rword == '0));

   generate
      if (PIPE) begin : g_pipe_chk
         // R4
         always @(negedge rck) begin
            if (arst_act) begin
               arst_clear_chk: assert (rd_data == '0);
            end
         end
         // R6
         oreg_hold_chk: assert property (@(posedge rck) disable iff (arst_act)
            !en_act |=> $stable(rd_data));
         // R7
         oreg_srst_chk: assert property (@(posedge rck) disable iff (arst_act)
            (en_act && srst_act) |=> (rd_data == '0));
         // R8
         oreg_load_chk: assert property (@(posedge rck) disable iff (arst_act)
            (en_act && !srst_act) |=> (rd_data == $past(rword)));
      end else begin : g_bypass_chk
         logic unused_chk;
         assign unused_chk = en_act ^ srst_act;
      end
   endgenerate
endmodule

bind mw_tpram mw_tpram_chk #(.PIPE(PIPE), .RW(RD_W)) u_chk (
   .rck     (rck),
   .arst_act(arst_act),
   .en_act  (oen_act),
   .srst_act(srst_act),
   .re_act  (re_act),
   .rword   (rword),
   .rd_data (rd_data)
);

// File: tb/sim_mw_tpram.sv
`timescale 1ns/1ps
module sim_mw_tpram;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   int checks = 0;
   int fails  = 0;

   // u0: 16-bit writes (16 deep), 8-bit reads (32 deep), output register on
   logic        a_we, a_re, a_oen, a_srst_n, a_arst_n;
   logic [3:0]  a_waddr;
   logic [15:0] a_wdata;
   logic [4:0]  a_raddr;
   logic [7:0]  a_rdata;
   logic [255:0] ref_a = '0;

   mw_tpram u0 (
      .clk(clk), .wr_clk(1'b0), .rd_clk(1'b0),
      .wr_en(a_we), .wr_addr(a_waddr), .wr_data(a_wdata),
      .rd_en(a_re), .rd_addr(a_raddr), .rd_data(a_rdata),
      .oreg_en(a_oen), .oreg_srst(a_srst_n), .oreg_arst(a_arst_n)
   );

   // u1: 8-bit writes (32 deep), 16-bit reads (16 deep), bypassed, active-low enables
   logic        b_we_n, b_re_n, b_oen, b_srst, b_arst;
   logic [4:0]  b_waddr;
   logic [7:0]  b_wdata;
   logic [3:0]  b_raddr;
   logic [15:0] b_rdata;
   logic [255:0] ref_b = '0;

   mw_tpram #(
      .WR_W(8), .WR_D(32), .RD_W(16), .RD_D(16), .PIPE(1'b0), .SINGLE_CLK(1'b0),
      .WE_POL(0), .RE_POL(0), .OE_POL(1), .SRST_POL(1), .ARST_POL(1)
   ) u1 (
      .clk(1'b0), .wr_clk(clk), .rd_clk(clk),
      .wr_en(b_we_n), .wr_addr(b_waddr), .wr_data(b_wdata),
      .rd_en(b_re_n), .rd_addr(b_raddr), .rd_data(b_rdata),
      .oreg_en(b_oen), .oreg_srst(b_srst), .oreg_arst(b_arst)
   );

   // {write address, write data} for u0
   localparam logic [19:0] A_VEC [8] = '{
      {4'd0, 16'hA5C3}, {4'd1, 16'h0F1E}, {4'd2, 16'h7B29}, {4'd5, 16'hC0DE},
      {4'd7, 16'h1234}, {4'd9, 16'hFFFF}, {4'd14, 16'h8001}, {4'd15, 16'h5A6B}
   };
   // {write address, write data} for u1
   localparam logic [12:0] B_VEC [8] = '{
      {5'd0, 8'h3C}, {5'd1, 8'h96}, {5'd6, 8'hE1}, {5'd7, 8'h47},
      {5'd20, 8'h0D}, {5'd21, 8'hB8}, {5'd30, 8'h72}, {5'd31, 8'hF9}
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic a_write(input int addr, input logic [15:0] data);
      @(negedge clk);
      a_we = 1'b1; a_waddr = 4'(addr); a_wdata = data;
      @(negedge clk);
      a_we = 1'b0;
      ref_a[addr*16 +: 16] = data;
   endtask

   task automatic a_read(input int addr, output logic [7:0] v);
      @(negedge clk);
      a_re = 1'b1; a_raddr = 5'(addr);
      @(negedge clk);
      @(negedge clk);
      v = a_rdata;
   endtask

   task automatic b_write(input int addr, input logic [7:0] data);
      @(negedge clk);
      b_we_n = 1'b0; b_waddr = 5'(addr); b_wdata = data;
      @(negedge clk);
      b_we_n = 1'b1;
      ref_b[addr*8 +: 8] = data;
   endtask

   task automatic b_read(input int addr, output logic [15:0] v);
      @(negedge clk);
      b_re_n = 1'b0; b_raddr = 4'(addr);
      @(negedge clk);
      v = b_rdata;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0]  va;
      logic [15:0] vb;
      int wa;
      a_we = 0; a_re = 0; a_oen = 1; a_srst_n = 1; a_arst_n = 0;
      a_waddr = '0; a_wdata = '0; a_raddr = '0;
      b_we_n = 1; b_re_n = 1; b_oen = 1; b_srst = 0; b_arst = 0;
      b_waddr = '0; b_wdata = '0; b_raddr = '0;
      repeat (3) @(negedge clk);
      check("R4 reset state", 16'(a_rdata), 16'h0);
      a_arst_n = 1;

      // R1: table walk, narrow-wide mapping both directions
      for (int i = 0; i < 8; i++) a_write(int'(A_VEC[i][19:16]), A_VEC[i][15:0]);
      for (int i = 0; i < 8; i++) begin
         wa = int'(A_VEC[i][19:16]);
         for (int h = 0; h < 2; h++) begin
            a_read(2*wa + h, va);
            check("R1 wide-write narrow-read", 16'(va), 16'(ref_a[(2*wa+h)*8 +: 8]));
         end
      end
      for (int i = 0; i < 8; i++) b_write(int'(B_VEC[i][12:8]), B_VEC[i][7:0]);
      foreach (B_VEC[i]) begin
         if (i % 2 == 0) begin
            b_read(int'(B_VEC[i][12:8]) / 2, vb);
            check("R1 R9 R10 narrow-write wide-read",
                  vb, ref_b[(int'(B_VEC[i][12:8])/2)*16 +: 16]);
         end
      end

      // R2: write enable inactive stores nothing
      @(negedge clk);
      a_we = 0; a_waddr = 4'd0; a_wdata = 16'hDEAD;
      @(negedge clk);
      a_read(0, va); check("R2 low half kept", 16'(va), 16'h00C3);
      a_read(1, va); check("R2 high half kept", 16'(va), 16'h00A5);
      @(negedge clk);
      b_we_n = 1; b_waddr = 5'd0; b_wdata = 8'h55;
      @(negedge clk);
      b_read(0, vb); check("R2 R10 active-low write off", vb, 16'h963C);

      // R3: read enable inactive yields zero
      @(negedge clk);
      a_re = 0; a_raddr = 5'd1;
      @(negedge clk); @(negedge clk);
      check("R3 pipelined read off", 16'(a_rdata), 16'h0);
      @(negedge clk);
      b_re_n = 1;
      @(negedge clk);
      check("R3 R10 bypass read off", b_rdata, 16'h0);

      // R6: register enable low holds
      a_read(0, va); check("R8 load before hold", 16'(va), 16'h00C3);
      @(negedge clk);
      a_oen = 0; a_raddr = 5'd1;
      @(negedge clk); @(negedge clk);
      check("R6 hold with enable low", 16'(a_rdata), 16'h00C3);

      // R7: sync clear ignored while enable low, effective when high
      a_srst_n = 0;
      @(negedge clk); @(negedge clk);
      check("R7 srst ignored when enable low", 16'(a_rdata), 16'h00C3);
      a_oen = 1;
      @(negedge clk);
      check("R7 srst clears when enabled", 16'(a_rdata), 16'h0);
      a_srst_n = 1;

      // R4/R5: async clear between edges, memory intact
      a_read(1, va); check("R8 load before async clear", 16'(va), 16'h00A5);
      #1;
      a_arst_n = 0;
      #0.5;
      check("R4 async clear without edge", 16'(a_rdata), 16'h0);
      @(negedge clk); @(negedge clk);
      check("R4 held while asserted", 16'(a_rdata), 16'h0);
      a_arst_n = 1;
      a_read(1, va); check("R5 memory survives async clear", 16'(va), 16'h00A5);

      // R8: two-edge latency
      @(negedge clk);
      a_raddr = 5'd2;
      @(negedge clk);
      check("R8 old word after one edge", 16'(a_rdata), 16'h00A5);
      @(negedge clk);
      check("R8 new word after two edges", 16'(a_rdata), 16'h001E);

      // R9: bypass ignores register controls
      b_read(3, vb); check("R9 bypass read", vb, 16'h47E1);
      b_oen = 0; b_srst = 1; b_arst = 1;
      #0.5;
      check("R9 async clear no effect", b_rdata, 16'h47E1);
      b_read(15, vb); check("R9 loads with controls asserted", vb, 16'hF972);
      b_read(10, vb); check("R9 one-edge latency", vb, 16'hB80D);
      b_oen = 1; b_srst = 0; b_arst = 0;

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule